// File: doc/BRIEF.md
# Prescaled Baud Rate Generator

This block derives the bit timing of an asynchronous serial channel from the peripheral clock. A 4-bit source code picks the base rate. It is either the peripheral clock divided by a power of two, from 1 up to 1024, or the rising edges of a pulse that an external timer supplies. An 8-bit divisor then counts base-rate events. Each time the count completes, a divide-by-two stage flips. The level of that stage is the baud clock, so the baud frequency is the base rate divided by twice the divisor.

All logic runs on the peripheral clock. Every base-rate event is a one-cycle enable, and no derived clock is used. The counter runs only while the channel is powered and at least one direction (transmit or receive) is enabled. An illegal source code or a divisor below four raises a configuration error and holds the counter in reset.

Top module: `uart_baud_gen`

## Requirements
- R1: For source codes 0 through 10 (clk_sel = n), one base event occurs every 2^n peripheral clock cycles, so `baud_tick` pulses every divisor × 2^n cycles.
- R2: Source code 11 takes the base events from rising edges of `timer_pulse`. The edges pass through a two-stage synchronizer, and each edge counts exactly once.
- R3: Source codes 12 to 15 raise `cfg_error`, and while it is raised `baud_tick` and `baud_level` stay 0.
- R4: A divisor of 0, 1, 2 or 3 raises `cfg_error` and holds `baud_tick` and `baud_level` at 0. Any divisor from 4 to 255 is legal.
- R5: With a legal setup, `baud_level` toggles once every divisor base events, so its full period is twice the divisor.
- R6: The counter runs only while `power_on` is 1 and `tx_en` or `rx_en` is 1. Either enable alone is enough. The cycle after the run condition drops, `baud_level` and `baud_tick` are 0.
- R7: After the run condition returns with source code 0 and divisor D, the first `baud_tick` and the rise of `baud_level` appear D cycles after the enabling edge.
- R8: `baud_tick` is a single-cycle pulse, and it is high exactly in the cycle in which `baud_level` takes its new toggled value.
- R9: While `rst_n` is low, and directly after reset, `baud_tick`, `baud_level` and the internal count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 4 | Base-rate source code (0..10 prescaler taps, 11 timer, 12..15 illegal) |
| divisor | input | 8 | Base events per half baud period, legal range 4..255 |
| power_on | input | 1 | Channel power bit |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| timer_pulse | input | 1 | Asynchronous pulse from an external timer |
| baud_tick | output | 1 | One-cycle pulse on each toggle of the baud level |
| baud_level | output | 1 | Baud clock level (divide-by-two stage) |
| cfg_error | output | 1 | Illegal source code or divisor below four |

## Verification
`cfg_error` is combinational, so the bench checks it half a cycle after it drives the inputs. Clearing on an illegal setup or on a dropped enable is registered and is checked at the next falling edge. When counting restarts from source 0, the first tick is due at the falling edge that follows the D-th rising edge. The bench checks that edge, and it also checks that the tick is absent at each of the falling edges before it. For prescaled sources the phase of the free-running prescaler is unknown, so the bench measures the cycles between consecutive ticks. For the timer source, each synchronized edge counts two rising edges after it arrives, and the bench allows that much slack before it reads the tick count.

// File: rtl/uart_baud_gen_pkg.sv
package uart_baud_gen_pkg;
    localparam int SEL_W        = 4;
    localparam int PRE_STAGES   = 10;
    localparam logic [SEL_W-1:0] SEL_LAST_TAP = 4'd10;
    localparam logic [SEL_W-1:0] SEL_TIMER    = 4'd11;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_state_t;
endpackage

// File: rtl/uart_baud_prescaler.sv
module uart_baud_prescaler #(
    parameter int STAGES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES:0]   taps
);
    logic [STAGES-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign taps[0] = 1'b1;
    for (genvar n = 1; n <= STAGES; n++) begin : g_tap
        assign taps[n] = &cnt_q[n-1:0];
    end
endmodule

// File: rtl/uart_baud_edge_sync.sv
module uart_baud_edge_sync
    import uart_baud_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;
endmodule

// File: rtl/uart_baud_divider.sv
module uart_baud_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             base_evt,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick,
    output logic             level
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             half;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = divisor - 1'b1;
        st_d = st_q;
        st_d.tick = 1'b0;
        if (!run) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
        end else if (base_evt) begin
            if (st_q.cnt == last) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick  = st_q.tick;
    assign level = st_q.half;
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_baud_gen_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       clk_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             power_on,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             timer_pulse,
    output logic             baud_tick,
    output logic             baud_level,
    output logic             cfg_error
);
    localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

    logic [PRE_STAGES:0] taps;
    logic                timer_rise;
    logic                base_evt;
    logic                sel_bad;
    logic                div_bad;
    logic                run;

    uart_baud_prescaler #(.STAGES(PRE_STAGES)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps)
    );

    uart_baud_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (timer_pulse),
        .rise     (timer_rise)
    );

    always_comb begin
        base_evt = 1'b0;
        if (clk_sel <= SEL_LAST_TAP) base_evt = taps[clk_sel];
        else if (clk_sel == SEL_TIMER) base_evt = timer_rise;
        sel_bad = clk_sel > SEL_TIMER;
        div_bad = divisor < MIN_DIV_V;
        run     = power_on & (tx_en | rx_en) & ~sel_bad & ~div_bad;
    end

    assign cfg_error = sel_bad | div_bad;

    uart_baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .base_evt (base_evt),
        .divisor  (divisor),
        .tick     (baud_tick),
        .level    (baud_level)
    );
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] divisor,
    input logic             power_on,
    input logic             tx_en,
    input logic             rx_en,
    input logic             baud_tick,
    input logic             baud_level,
    input logic             cfg_error
);
    // R8: ticks are at least four cycles apart, so a tick is never followed by another
    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    // R8: a tick marks a change of the level
    assert_tick_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> (baud_level != $past(baud_level)));

    // R5: outside a tick the level only changes by clearing to zero
    assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && (baud_level != $past(baud_level))) |-> !baud_level);

    // R3: a configuration error clears the outputs on the next cycle
    assert_err_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> (!baud_tick && !baud_level));

    // R4: a short divisor stops the divider
    assert_short_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor < DIV_W'(4)) |=> !baud_tick);

    // R6: without power and a direction enable the outputs are idle
    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_on && (tx_en || rx_en)) |=> (!baud_tick && !baud_level));
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .divisor    (divisor),
    .power_on   (power_on),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .baud_tick  (baud_tick),
    .baud_level (baud_level),
    .cfg_error  (cfg_error)
);

// File: tb/uart_baud_gen_bench.sv
module uart_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] clk_sel = '0;
    logic [7:0] divisor = 8'd4;
    logic       power_on = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       timer_pulse = 1'b0;
    logic       baud_tick;
    logic       baud_level;
    logic       cfg_error;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_baud_gen u_uart_baud_gen (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .divisor(divisor),
        .power_on(power_on), .tx_en(tx_en), .rx_en(rx_en),
        .timer_pulse(timer_pulse), .baud_tick(baud_tick),
        .baud_level(baud_level), .cfg_error(cfg_error)
    );

    always @(negedge clk) if (baud_tick) tick_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // waits at negedges for a tick; returns cycles waited, -1 on timeout
    task automatic wait_tick(input int limit, output int cycles);
        cycles = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (baud_tick) begin cycles = i; break; end
        end
    endtask

    task automatic setup(input logic [3:0] s, input logic [7:0] d,
                         input logic p, input logic t, input logic r);
        @(negedge clk);
        clk_sel = s; divisor = d; power_on = p; tx_en = t; rx_en = r;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R9 tick in reset", baud_tick, 0);
        check("R9 level in reset", baud_level, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 tick after reset", baud_tick, 0);
        check("R9 level after reset", baud_level, 0);
    endtask

    task automatic test_rate(input logic [3:0] s, input logic [7:0] d,
                             input logic t, input logic r, input string req);
        int c;
        int exp;
        logic lv;
        exp = int'(d) << s;
        setup(s, d, 1'b1, t, r);
        wait_tick(2 * exp + 8, c);
        lv = baud_level;
        wait_tick(2 * exp + 8, c);
        check({req, " tick interval"}, c, exp);
        check("R5 level toggles each tick", baud_level, int'(!lv));
        @(negedge clk);
        check("R8 tick lasts one cycle", baud_tick, 0);
    endtask

    task automatic test_timer();
        int c0;
        setup(4'd11, 8'd4, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        c0 = tick_cnt;
        for (int k = 0; k < 4; k++) begin
            timer_pulse = 1'b1; repeat (2) @(negedge clk);
            timer_pulse = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R2 ticks after four timer edges", tick_cnt - c0, 1);
        check("R2 level after four timer edges", baud_level, 1);
        repeat (20) @(negedge clk);
        check("R2 no tick without timer edges", tick_cnt - c0, 1);
        for (int k = 0; k < 4; k++) begin
            timer_pulse = 1'b1; repeat (3) @(negedge clk);
            timer_pulse = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R2 ticks after eight timer edges", tick_cnt - c0, 2);
        check("R5 level after eight timer edges", baud_level, 0);
    endtask

    task automatic test_bad_sel();
        for (int s = 12; s < 16; s++) begin
            setup(4'(s), 8'd4, 1'b1, 1'b1, 1'b1);
            #1 check("R3 error flag on illegal code", cfg_error, 1);
            @(negedge clk);
            check("R3 level held on illegal code", baud_level, 0);
        end
        tick_cnt = 0;
        repeat (30) @(negedge clk);
        check("R3 no ticks on illegal code", tick_cnt, 0);
    endtask

    task automatic test_bad_div();
        for (int d = 0; d < 5; d++) begin
            setup(4'd0, 8'(d), 1'b1, 1'b1, 1'b0);
            #1 check("R4 error flag vs divisor", cfg_error, int'(d < 4));
        end
        setup(4'd0, 8'd3, 1'b1, 1'b1, 1'b0);
        tick_cnt = 0;
        repeat (30) @(negedge clk);
        check("R4 no ticks with divisor 3", tick_cnt, 0);
        check("R4 level held with divisor 3", baud_level, 0);
    endtask

    task automatic test_gating();
        int c;
        setup(4'd0, 8'd6, 1'b1, 1'b1, 1'b0);
        wait_tick(20, c);
        if (!baud_level) wait_tick(20, c);
        check("R6 level high before gating", baud_level, 1);
        setup(4'd0, 8'd6, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R6 level cleared on power off", baud_level, 0);
        tick_cnt = 0;
        repeat (30) @(negedge clk);
        check("R6 no ticks with power off", tick_cnt, 0);
        setup(4'd0, 8'd6, 1'b1, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        check("R6 no ticks with no direction", tick_cnt, 0);
    endtask

    task automatic test_restart(input logic [7:0] d);
        setup(4'd0, d, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        power_on = 1'b1; rx_en = 1'b1;
        for (int i = 1; i < int'(d); i++) begin
            @(negedge clk);
            if (baud_tick) check("R7 early tick", 1, 0);
        end
        @(negedge clk);
        check("R7 first tick after restart", baud_tick, 1);
        check("R7 level after restart", baud_level, 1);
    endtask

    initial begin
        test_reset();
        test_rate(4'd0, 8'd4, 1'b1, 1'b0, "R1 R5 code0 div4");
        test_rate(4'd0, 8'd255, 1'b0, 1'b1, "R5 code0 div255");
        test_rate(4'd3, 8'd7, 1'b1, 1'b1, "R1 code3 div7");
        test_rate(4'd10, 8'd4, 1'b1, 1'b0, "R1 code10 div4");
        test_timer();
        test_bad_sel();
        test_bad_div();
        test_gating();
        test_restart(8'd5);
        test_restart(8'd9);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule